// File: doc/BRIEF.md
# Forward Three-Rule Pair Decoder

This block decodes a rate one-half systematic inner code in which each information bit is sent as a two-bit pair. The encoder's trellis restricts which pair may follow which. Received hard-decision pairs arrive one per cycle, and a frame is marked by start and end flags. The block walks each frame once from left to right. For every pair position it emits three decoded symbols, one from each of three repair rules that run side by side. Each symbol is 0, 1 or discarded. A discarded symbol is signalled by a cleared validity bit.

The first pair of a frame is repaired using the pair after it. The last pair is decoded as received. Every pair in between goes to three rules. The first is a transition-checked repair rule that uses the next pair when the trellis step is illegal. The second is a neighbour rule that never checks legality. The third is an erasure rule that marks illegal steps as discarded. A one-pair lookahead buffer supplies the next pair, so all three symbol streams leave aligned and carry shared start and end flags. Downstream logic can combine the three streams into per-bit reliability.

Top module: `fwd_multipath_decoder`

## Requirements
- R1: Bit 1 of a pair is its first received bit. A step from a preceding pair P to pair C is legal exactly when C is 01 or 10 and P's first bit is 0, or C is 00 or 11 and P's first bit is 1.
- R2: A first pair of 01 or 10 is kept. All three paths decode it to its first bit, with validity 1.
- R3: A first pair of 00 or 11 is replaced using the second pair. If the second pair is 01 or 10, the first pair becomes 01 and decodes to 0. If the second pair is 00 or 11, it becomes 10 and decodes to 1. All three paths give the same result, with validity 1.
- R4: The last pair of a frame is never altered. All three paths decode it to its first bit, with validity 1.
- R5: Erasure path: for an interior pair, a legal step from the received preceding pair gives the pair's first bit with validity 1. An illegal step gives validity 0.
- R6: Neighbour path: an interior pair decodes to 1 when it is 00 or 11 and to 0 when it is 01 or 10, whatever the step legality. The pair is then rewritten to the legal successor of the path's preceding pair that carries that bit. Successors are 01 or 10 after a first bit of 0, and 00 or 11 after a first bit of 1.
- R7: Repair path: for an interior pair on a legal step, the output is its first bit. On an illegal step, the output is 1 if the next pair is 00 or 11 and 0 otherwise, and the pair is rewritten to the legal successor carrying that bit. Validity is always 1.
- R8: On the repair and neighbour paths, the rewritten pair, not the received one, is the preceding pair for the next position.
- R9: Position k of a frame is output one cycle after the pair at position k+1 is accepted. The last position is output the cycle after the end pair is accepted. Idle input cycles inside a frame produce no output. The start flag marks position 0 and the end flag marks the last position.
- R10: While reset is low, and in the first cycle after it, no output is valid. A partly received frame is dropped by reset.
- R11: A frame of one pair, with start and end flags both set, decodes by the last-pair rule and carries both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A received pair is present |
| in_pair | input | 2 | Hard-decision pair, bit 1 received first |
| in_sof | input | 1 | Pair is the first of a frame |
| in_eof | input | 1 | Pair is the last of a frame |
| out_valid | output | 1 | One position is being output |
| out_sof | output | 1 | Output position is the first of a frame |
| out_eof | output | 1 | Output position is the last of a frame |
| out_rep_bit | output | 1 | Repair path decoded bit |
| out_rep_ok | output | 1 | Repair path symbol validity |
| out_nbr_bit | output | 1 | Neighbour path decoded bit |
| out_nbr_ok | output | 1 | Neighbour path symbol validity |
| out_era_bit | output | 1 | Erasure path decoded bit |
| out_era_ok | output | 1 | Erasure path symbol validity, 0 means discarded |

## Verification
Several properties are checked on every cycle. Each rewritten pair on the repair and neighbour paths must be a legal successor of the one before it. An illegal received step must show up as a discarded erasure symbol. Both frame ends must be valid and agree across paths. The repair and neighbour streams must never carry a discarded symbol. The end flag must follow an output in the cycle before it. The bench's frame scenarios are needed for the rest: the exact bit each rule picks, the effect of a rewritten preceding pair on later positions, the lookahead latency, back-to-back and gapped frames, one-pair frames, and dropping a partial frame on reset.

// File: rtl/fmpd_pkg.sv
// Package: shared pair and symbol types plus the trellis helper functions.
// Assumes bit 1 of every pair is the first received bit.
package fmpd_pkg;

    localparam int PAIR_W    = 2;
    localparam int NUM_PATHS = 3;

    typedef logic [PAIR_W-1:0] pair_t;

    typedef struct packed {
        logic ok;   // 0 marks a discarded symbol
        logic val;  // decoded bit
    } sym_t;

    typedef enum logic [1:0] {
        PATH_REPAIR = 2'd0,
        PATH_NBR    = 2'd1,
        PATH_ERASE  = 2'd2
    } path_e;

    typedef enum logic [1:0] {
        STEP_FIRST = 2'd0,
        STEP_MID   = 2'd1,
        STEP_LAST  = 2'd2
    } step_e;

    // Legal trellis step: the parity of cur must differ from prv's first bit.
    function automatic logic pair_follows(input pair_t prv, input pair_t cur);
        return (cur[1] ^ cur[0]) != prv[1];
    endfunction

    // Legal successor of prv whose first bit is d.
    function automatic pair_t successor(input pair_t prv, input logic d);
        return {d, d ^ ~prv[1]};
    endfunction

    // Repaired first pair: keep 01/10, else choose from the second pair's parity.
    function automatic pair_t first_fix(input pair_t first, input pair_t second);
        if (first[1] ^ first[0])
            return first;
        return (second[1] ^ second[0]) ? 2'b01 : 2'b10;
    endfunction

endpackage

// File: rtl/fmpd_lookahead.sv
// Lookahead buffer: holds one pair until the following pair (or frame end)
// is known, then issues one decode step. Assumes every frame begins with
// in_sof and that a frame's pairs are not interleaved with another frame.
module fmpd_lookahead
    import fmpd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  pair_t in_pair,
    input  logic  in_sof,
    input  logic  in_eof,
    output logic  step,
    output step_e step_kind,
    output logic  step_sof,
    output logic  step_eof,
    output pair_t cur_pair,
    output pair_t nxt_pair
);

    pair_t buf_pair;
    logic  buf_full;
    logic  buf_first;
    logic  buf_last;

    // Step whenever the held pair has its follower or is the frame's last.
    always_comb begin : step_select
        step      = buf_full && (buf_last || in_valid);
        step_sof  = buf_first;
        step_eof  = buf_last;
        cur_pair  = buf_pair;
        nxt_pair  = in_pair;
        if (buf_last)
            step_kind = STEP_LAST;
        else if (buf_first)
            step_kind = STEP_FIRST;
        else
            step_kind = STEP_MID;
    end

    // Buffer update: a pending last pair always drains, freeing the slot.
    always_ff @(posedge clk) begin : buffer_update
        if (!rst_n) begin
            buf_pair  <= '0;
            buf_full  <= 1'b0;
            buf_first <= 1'b0;
            buf_last  <= 1'b0;
        end else if (in_valid) begin
            buf_pair  <= in_pair;
            buf_full  <= 1'b1;
            buf_first <= in_sof;
            buf_last  <= in_eof;
        end else if (buf_last) begin
            buf_full  <= 1'b0;
            buf_first <= 1'b0;
            buf_last  <= 1'b0;
        end
    end

    // R9: an accepted end pair is decoded in the very next cycle.
    assert_eof_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof) |=> (step && step_eof));

endmodule

// File: rtl/fmpd_path.sv
// One decoding path. MODE picks the rule used for interior pairs. The first
// and last pairs use shared rules. The path keeps its own preceding pair,
// which is the rewritten pair where the rule rewrites. Output is registered.
module fmpd_path
    import fmpd_pkg::*;
#(
    parameter path_e MODE = PATH_REPAIR
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    input  step_e kind,
    input  pair_t cur,
    input  pair_t nxt,
    output sym_t  sym_q
);

    pair_t prev_q;
    pair_t mid_pair;
    logic  mid_ok;
    pair_t new_prev;
    sym_t  sym_d;

    generate
        if (MODE == PATH_REPAIR) begin : g_repair
            // Keep a legal pair, else rebuild it with the bit chosen by the next pair.
            always_comb begin : repair_rule
                if (pair_follows(prev_q, cur))
                    mid_pair = cur;
                else
                    mid_pair = successor(prev_q, ~(nxt[1] ^ nxt[0]));
                mid_ok = 1'b1;
            end
            // R8: the stored preceding pair always steps legally.
            assert_rewrite_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (step && kind == STEP_MID) |=> pair_follows($past(prev_q), prev_q));
        end else if (MODE == PATH_NBR) begin : g_nbr
            // Bit from the pair's own parity, rewritten onto the trellis.
            always_comb begin : nbr_rule
                mid_pair = successor(prev_q, ~(cur[1] ^ cur[0]));
                mid_ok   = 1'b1;
            end
            // R6/R8: neighbour rewrites are legal successors.
            assert_nbr_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (step && kind == STEP_MID) |=> pair_follows($past(prev_q), prev_q));
        end else begin : g_erase
            // Pass the first bit and mark an illegal step as discarded.
            always_comb begin : erase_rule
                mid_pair = cur;
                mid_ok   = pair_follows(prev_q, cur);
            end
            // R5: an illegal received step leaves a discarded symbol.
            assert_erase_marks_x_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (step && kind == STEP_MID && !pair_follows(prev_q, cur)) |=> !sym_q.ok);
        end
    endgenerate

    // Choose the frame-end rule or the interior rule for this step.
    always_comb begin : step_rule
        case (kind)
            STEP_FIRST: begin
                new_prev = first_fix(cur, nxt);
                sym_d.ok = 1'b1;
            end
            STEP_LAST: begin
                new_prev = cur;
                sym_d.ok = 1'b1;
            end
            default: begin
                new_prev = mid_pair;
                sym_d.ok = mid_ok;
            end
        endcase
        sym_d.val = new_prev[1];
    end

    // Register the symbol and the preceding pair on each step.
    always_ff @(posedge clk) begin : path_state
        if (!rst_n) begin
            sym_q  <= '0;
            prev_q <= '0;
        end else if (step) begin
            sym_q  <= sym_d;
            prev_q <= new_prev;
        end
    end

endmodule

// File: rtl/fwd_multipath_decoder.sv
// Top: a lookahead buffer feeding three parallel decoding paths (repair,
// neighbour, erasure). The paths emit aligned symbols with shared frame
// flags. Assumes frames of one or more pairs, each opened by in_sof.
module fwd_multipath_decoder
    import fmpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [1:0] in_pair,
    input  logic       in_sof,
    input  logic       in_eof,
    output logic       out_valid,
    output logic       out_sof,
    output logic       out_eof,
    output logic       out_rep_bit,
    output logic       out_rep_ok,
    output logic       out_nbr_bit,
    output logic       out_nbr_ok,
    output logic       out_era_bit,
    output logic       out_era_ok
);

    logic  step;
    step_e step_kind;
    logic  step_sof;
    logic  step_eof;
    pair_t cur_pair;
    pair_t nxt_pair;
    sym_t  path_sym [NUM_PATHS];

    fmpd_lookahead u_look (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_pair  (in_pair),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .step     (step),
        .step_kind(step_kind),
        .step_sof (step_sof),
        .step_eof (step_eof),
        .cur_pair (cur_pair),
        .nxt_pair (nxt_pair)
    );

    for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
        fmpd_path #(.MODE(path_e'(g))) u_path (
            .clk  (clk),
            .rst_n(rst_n),
            .step (step),
            .kind (step_kind),
            .cur  (cur_pair),
            .nxt  (nxt_pair),
            .sym_q(path_sym[g])
        );
    end

    // Frame flags registered in step with the path symbols.
    always_ff @(posedge clk) begin : out_flags
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
        end else begin
            out_valid <= step;
            out_sof   <= step && step_sof;
            out_eof   <= step && step_eof;
        end
    end

    assign out_rep_bit = path_sym[PATH_REPAIR].val;
    assign out_rep_ok  = path_sym[PATH_REPAIR].ok;
    assign out_nbr_bit = path_sym[PATH_NBR].val;
    assign out_nbr_ok  = path_sym[PATH_NBR].ok;
    assign out_era_bit = path_sym[PATH_ERASE].val;
    assign out_era_ok  = path_sym[PATH_ERASE].ok;

    // R2/R3/R4: frame-end positions are valid on every path.
    assert_ends_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_sof || out_eof)) |-> (out_rep_ok && out_nbr_ok && out_era_ok));

    // R3: the first position is decoded identically by all paths.
    assert_first_shared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sof) |-> (out_rep_bit == out_nbr_bit && out_nbr_bit == out_era_bit));

    // R6/R7: repair and neighbour paths never discard.
    assert_no_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_rep_ok && out_nbr_ok));

    // R9: in a multi-pair frame the last position directly follows an output.
    assert_last_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eof && !out_sof) |-> $past(out_valid));

endmodule

// File: tb/fwd_multipath_decoder_tb.sv
module fwd_multipath_decoder_tb;

    localparam int NF = 6;
    // Frame table: pair k at bits [2k+1:2k]; expected bit k per path.
    localparam logic [15:0] F_PAIRS [NF] = '{16'b0000_0000_1101_0010, 16'b0000_1000_1011_0100,
        16'b0000_0001_0001_1111, 16'b0000_0000_0000_1101, 16'b0000_0000_0000_0011,
        16'b0000_0000_0010_0000};
    localparam int F_LEN [NF] = '{4, 6, 5, 2, 1, 3};
    localparam logic [7:0] F_REP [NF] = '{8'b0000_1001, 8'b0010_1000, 8'b0000_0111,
        8'b0000_0010, 8'b0000_0001, 8'b0000_0101};
    localparam logic [7:0] F_NBR [NF] = '{8'b0000_1011, 8'b0011_0100, 8'b0000_1011,
        8'b0000_0010, 8'b0000_0001, 8'b0000_0111};
    localparam logic [7:0] F_ERA [NF] = '{8'b0000_1001, 8'b0010_0000, 8'b0000_0011,
        8'b0000_0010, 8'b0000_0001, 8'b0000_0101};
    localparam logic [7:0] F_OK  [NF] = '{8'b0000_1111, 8'b0011_0011, 8'b0001_0011,
        8'b0000_0011, 8'b0000_0001, 8'b0000_0111};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] in_pair = 2'b00;
    logic in_sof = 1'b0;
    logic in_eof = 1'b0;
    logic out_valid, out_sof, out_eof;
    logic out_rep_bit, out_rep_ok, out_nbr_bit, out_nbr_ok, out_era_bit, out_era_ok;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    int exp_q [32];
    int exp_wr = 0;
    int mon_idx = 0;
    int mon_pos = 0;

    always #10 clk = ~clk;

    fwd_multipath_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pair(in_pair),
        .in_sof(in_sof), .in_eof(in_eof), .out_valid(out_valid), .out_sof(out_sof),
        .out_eof(out_eof), .out_rep_bit(out_rep_bit), .out_rep_ok(out_rep_ok),
        .out_nbr_bit(out_nbr_bit), .out_nbr_ok(out_nbr_ok), .out_era_bit(out_era_bit),
        .out_era_ok(out_era_ok)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Output monitor: compares each emitted position against the frame table.
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (mon_idx >= exp_wr) begin
                check("R9", "unexpected output", 1, 0);
            end else begin
                int id;
                bit first, last;
                string rr, rn, re;
                id = exp_q[mon_idx];
                first = (mon_pos == 0);
                last = (mon_pos == F_LEN[id] - 1);
                if (F_LEN[id] == 1) begin rr = "R11"; rn = "R11"; re = "R11"; end
                else if (first) begin
                    rr = (F_PAIRS[id][1] ^ F_PAIRS[id][0]) ? "R2" : "R3";
                    rn = rr; re = rr;
                end else if (last) begin rr = "R4"; rn = "R4"; re = "R4"; end
                else begin rr = "R7/R8"; rn = "R6/R8"; re = "R1/R5"; end
                check(rr, "repair bit", int'(out_rep_bit), int'(F_REP[id][mon_pos]));
                check(rr, "repair ok", int'(out_rep_ok), 1);
                check(rn, "neighbour bit", int'(out_nbr_bit), int'(F_NBR[id][mon_pos]));
                check(rn, "neighbour ok", int'(out_nbr_ok), 1);
                check(re, "erasure ok", int'(out_era_ok), int'(F_OK[id][mon_pos]));
                if (F_OK[id][mon_pos])
                    check(re, "erasure bit", int'(out_era_bit), int'(F_ERA[id][mon_pos]));
                check("R9", "sof flag", int'(out_sof), int'(first));
                check("R9", "eof flag", int'(out_eof), int'(last));
                if (last) begin mon_idx++; mon_pos = 0; end
                else mon_pos++;
            end
        end
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL R9 watchdog: actual=%0d expected=<20000", cycles);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Drive one frame; gap idle cycles follow each non-final pair.
    task automatic send_frame(input int id, input int gap, input bit check_first);
        exp_q[exp_wr] = id;
        exp_wr++;
        for (int k = 0; k < F_LEN[id]; k++) begin
            in_valid = 1'b1;
            in_pair = F_PAIRS[id][2*k +: 2];
            in_sof = (k == 0);
            in_eof = (k == F_LEN[id] - 1);
            @(negedge clk);
            if (check_first && k == 0)
                check("R9", "first pair held for lookahead", int'(out_valid), 0);
            if (k != F_LEN[id] - 1) begin
                for (int g = 0; g < gap; g++) begin
                    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
                    @(negedge clk);
                    check("R9", "idle cycle output", int'(out_valid), 0);
                end
            end
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10", "valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "valid after reset", int'(out_valid), 0);
        check("R10", "sof after reset", int'(out_sof), 0);
        check("R10", "eof after reset", int'(out_eof), 0);

        // Table walk: every frame, back to back.
        send_frame(0, 0, 1'b1);
        for (int f = 1; f < NF; f++) send_frame(f, 0, 1'b0);
        // Gapped frame and a one-pair frame followed at once by another frame.
        send_frame(2, 2, 1'b0);
        send_frame(4, 0, 1'b0);
        send_frame(0, 0, 1'b0);
        repeat (3) @(negedge clk);
        check("R9", "all positions emitted", mon_idx, exp_wr);

        // Reset during a frame drops the held pair.
        in_valid = 1'b1; in_pair = 2'b11; in_sof = 1'b1; in_eof = 1'b0;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10", "valid during reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "valid after mid-frame reset", int'(out_valid), 0);
        send_frame(3, 0, 1'b1);
        send_frame(1, 1, 1'b0);
        repeat (4) @(negedge clk);
        check("R9", "all positions emitted at end", mon_idx, exp_wr);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule